// File: doc/BRIEF.md
# Privilege-Filtered Fixed Event Counters

This block holds three dedicated 40-bit event counters. Each one is wired to a single event source: retired instructions, core clock cycles while not halted, and reference clock cycles while not halted. No event selection is involved. A single control register decides when each counter advances. It holds one 4-bit field per counter, and the two low bits of that field gate the counter by the current privilege ring.

Each cycle the surrounding core presents three event pulses and the current ring. Software reaches the counters and the control register through a simple single-cycle register port with combinational read data. A write that would put a nonzero value into reserved bits is refused and reported. A counter that wraps past its top value pulses an overflow output.

Top module: `fixed_ctr_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every counter reads 0, the control register reads 0, and `ctr_ovf` and `reg_err` are 0.
- R2: Counter 0, 1 and 2 are reached at addresses 0x309, 0x30A and 0x30B, and the control register at 0x38D. Any other address reads 0, and a write to it changes nothing and raises no error.
- R3: Counter 0 counts `ev_retired`, counter 1 counts `ev_core_cyc` and counter 2 counts `ev_ref_cyc`. A counter advances by exactly one on each clock edge where its event input is high and the event is enabled for the current ring.
- R4: For counter n, control bit 4n enables counting when `cur_ring` is 0, and bit 4n+1 enables counting when `cur_ring` is nonzero. A field value of 00 freezes the counter, and 11 counts in every ring.
- R5: Control bits 4n+2 and 4n+3 are stored and read back, but they have no effect on counting.
- R6: A write to a counter with data bits [63:40] all zero loads bits [39:0] at the next edge. In that same cycle the write wins over any increment.
- R7: Reading a counter returns the value it held at the start of the cycle. That cycle's increment is not included.
- R8: A write with any reserved bit set is refused and the target register keeps its old value. For a counter the reserved bits are [63:40], and for the control register they are [63:12]. `reg_err` is then high for the one following cycle. A refused counter write does not block that counter's increment.
- R9: A counter at 2^40-1 that increments becomes 0. Its `ctr_ovf` bit is high for exactly the cycle in which the counter first reads 0.
- R10: A control write governs events from the next edge onward. Events in the cycle of the write are filtered by the previous control value.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| reg_err | output | 1 | Reserved-bit write refused (pulse) |
| cur_ring | input | 2 | Current privilege ring, 0 is most privileged |
| ev_retired | input | 1 | Instruction retired this cycle |
| ev_core_cyc | input | 1 | Unhalted core cycle |
| ev_ref_cyc | input | 1 | Unhalted reference cycle |
| ctr_ovf | output | 3 | Per-counter wrap pulse |

## Verification
The assertions assume that every input is a known value at each rising edge and that reset lasts at least one edge. They also assume that a write is a single-cycle strobe whose address and data are steady for that edge, and that the event pulses and ring are sampled only at that edge. The bench drives every input on the falling edge from fixed or pseudo-random values, never leaves an input undriven, and holds reset for several cycles. A behavioural model predicts the read data, overflow and error outputs on every cycle. The stimulus covers loads at and near the wrap value, writes that collide with increments, and control rewrites made while events are active.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
    parameter int NUM_CTR = 3;
    parameter int CNT_W   = 40;
    parameter int REG_W   = 64;
    parameter int ADDR_W  = 12;
    parameter int FLD_W   = 4;
    parameter int RING_W  = 2;

    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int CTRL_W = NUM_CTR * FLD_W;

    localparam logic [ADDR_W-1:0] CTR_BASE  = 12'h309;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h38D;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTR  = 2'd1,
        SEL_CTRL = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic ring_hi;   // count when ring is nonzero
        logic ring0;     // count when ring is zero
    } ring_en_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t          s;
        logic [ADDR_W-1:0] off;
        s.kind = SEL_NONE;
        s.idx  = '0;
        off    = a - CTR_BASE;
        if (a >= CTR_BASE && off < ADDR_W'(NUM_CTR)) begin
            s.kind = SEL_CTR;
            s.idx  = off[IDX_W-1:0];
        end else if (a == CTRL_ADDR) begin
            s.kind = SEL_CTRL;
        end
        return s;
    endfunction

    function automatic ring_en_t field_enables(input logic [FLD_W-1:0] f);
        ring_en_t e;
        e.ring0   = f[0];
        e.ring_hi = f[1];
        return e;
    endfunction

    function automatic logic ring_match(input ring_en_t e, input logic [RING_W-1:0] ring);
        return (ring == '0) ? e.ring0 : e.ring_hi;
    endfunction
endpackage

// File: rtl/fxc_counter.sv
module fxc_counter
    import fxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              event_i,
    input  ring_en_t          en_i,
    input  logic [RING_W-1:0] ring_i,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_val_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             inc;

    always_comb inc = event_i && ring_match(en_i, ring_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_i) begin
                cnt_q <= load_val_i;
            end else if (inc) begin
                cnt_q <= cnt_q + CNT_ONE;
                ovf_q <= (cnt_q == CNT_MAX);
            end
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R3: no event and no load leaves the count alone
    p_hold_no_event_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !event_i) |=> $stable(cnt_q));
    // R3: an enabled event advances by one, modulo the width
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && event_i && ring_match(en_i, ring_i)) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
    // R4: a field with both enables clear freezes the counter
    p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && en_i == '0) |=> $stable(cnt_q));
    // R6: load wins and never reports a wrap
    p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i) && !ovf_o));
    // R9: overflow is seen only with a zero count, for one cycle
    p_wrap_zero_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (cnt_q == '0));
    p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o);
endmodule

// File: rtl/fxc_ctrl_reg.sv
module fxc_ctrl_reg
    import fxc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_i,
    input  logic [CTRL_W-1:0]         wdata_i,
    output logic [CTRL_W-1:0]         ctrl_o,
    output ring_en_t [NUM_CTR-1:0]    en_o
);
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (wr_i) ctrl_q <= wdata_i;
    end

    assign ctrl_o = ctrl_q;

    // only the two low bits of each field reach the counters (R5)
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_field
        assign en_o[n] = field_enables(ctrl_q[n*FLD_W +: FLD_W]);
    end

    // R8: without an accepted write the control value holds
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(ctrl_q));
    // R10: an accepted write is visible from the next cycle
    p_ctrl_take_r10: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (ctrl_q == $past(wdata_i)));
endmodule

// File: rtl/fxc_regif.sv
module fxc_regif
    import fxc_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [REG_W-1:0]                wdata_i,
    input  logic [NUM_CTR-1:0][CNT_W-1:0]   cnt_i,
    input  logic [CTRL_W-1:0]               ctrl_i,
    output logic [NUM_CTR-1:0]              load_o,
    output logic [CNT_W-1:0]                load_val_o,
    output logic                            ctrl_wr_o,
    output logic [CTRL_W-1:0]               ctrl_wdata_o,
    output logic [REG_W-1:0]                rdata_o,
    output logic                            err_o
);
    reg_sel_t sel;
    logic     ctr_rsvd;
    logic     ctrl_rsvd;
    logic     bad_wr;
    logic     err_q;

    always_comb begin
        sel       = decode_addr(addr_i);
        ctr_rsvd  = |wdata_i[REG_W-1:CNT_W];
        ctrl_rsvd = |wdata_i[REG_W-1:CTRL_W];
        bad_wr    = we_i && ((sel.kind == SEL_CTR  && ctr_rsvd) ||
                             (sel.kind == SEL_CTRL && ctrl_rsvd));
        ctrl_wr_o = we_i && sel.kind == SEL_CTRL && !ctrl_rsvd;
    end

    assign load_val_o   = wdata_i[CNT_W-1:0];
    assign ctrl_wdata_o = wdata_i[CTRL_W-1:0];

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_load
        assign load_o[n] = we_i && !ctr_rsvd && sel.kind == SEL_CTR &&
                           sel.idx == IDX_W'(n);
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel.kind)
            SEL_CTR: begin
                for (int n = 0; n < NUM_CTR; n++) begin
                    if (sel.idx == IDX_W'(n)) rdata_o = {{(REG_W-CNT_W){1'b0}}, cnt_i[n]};
                end
            end
            SEL_CTRL: rdata_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_i};
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= bad_wr;
    end

    assign err_o = err_q;

    // R2: a write targets at most one counter
    p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_o));
    // R8: reserved counter bits block every load
    p_no_bad_load_r8: assert property (@(posedge clk) disable iff (rst)
        (we_i && |wdata_i[REG_W-1:CNT_W]) |-> (load_o == '0));
    // R8: an error is only ever the echo of a write
    p_err_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(we_i));
endmodule

// File: rtl/fixed_ctr_bank.sv
module fixed_ctr_bank
    import fxc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        reg_err,
    input  logic [1:0]  cur_ring,
    input  logic        ev_retired,
    input  logic        ev_core_cyc,
    input  logic        ev_ref_cyc,
    output logic [2:0]  ctr_ovf
);
    logic [NUM_CTR-1:0]            events;
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt;
    logic [NUM_CTR-1:0]            load;
    logic [CNT_W-1:0]              load_val;
    logic                          ctrl_wr;
    logic [CTRL_W-1:0]             ctrl_wdata;
    logic [CTRL_W-1:0]             ctrl_val;
    ring_en_t [NUM_CTR-1:0]        en;

    // fixed wiring of events to counters (R3)
    assign events = {ev_ref_cyc, ev_core_cyc, ev_retired};

    fxc_regif u_regif (
        .clk          (clk),
        .rst          (rst),
        .we_i         (reg_we),
        .addr_i       (reg_addr),
        .wdata_i      (reg_wdata),
        .cnt_i        (cnt),
        .ctrl_i       (ctrl_val),
        .load_o       (load),
        .load_val_o   (load_val),
        .ctrl_wr_o    (ctrl_wr),
        .ctrl_wdata_o (ctrl_wdata),
        .rdata_o      (reg_rdata),
        .err_o        (reg_err)
    );

    fxc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctrl_wr),
        .wdata_i (ctrl_wdata),
        .ctrl_o  (ctrl_val),
        .en_o    (en)
    );

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        fxc_counter u_ctr (
            .clk        (clk),
            .rst        (rst),
            .event_i    (events[n]),
            .en_i       (en[n]),
            .ring_i     (cur_ring),
            .load_i     (load[n]),
            .load_val_i (load_val),
            .cnt_o      (cnt[n]),
            .ovf_o      (ctr_ovf[n])
        );
    end

    // R1: outputs are quiet in the cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (ctr_ovf == '0 && !reg_err));
endmodule

// File: tb/fixed_ctr_bank_tb_top.sv
module fixed_ctr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic [1:0]  cur_ring = '0;
    logic [2:0]  ev = '0;
    logic [2:0]  ctr_ovf;

    always #4 clk = ~clk;  // 125 MHz

    fixed_ctr_bank dut_i (
        .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .reg_err (reg_err),
        .cur_ring (cur_ring), .ev_retired (ev[0]), .ev_core_cyc (ev[1]),
        .ev_ref_cyc (ev[2]), .ctr_ovf (ctr_ovf)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase_tag = "R1";

    // behavioural reference
    logic [39:0] m_cnt [3];
    logic [11:0] m_ctrl;
    logic [2:0]  m_ovf;
    logic        m_err;

    function automatic logic [63:0] model_read(input logic [11:0] a);
        for (int n = 0; n < 3; n++)
            if (a == 12'h309 + n) return {24'h0, m_cnt[n]};
        if (a == 12'h38D) return {52'h0, m_ctrl};
        return 64'h0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [2:0]  n_ovf = '0;
        logic        n_err = 1'b0;
        logic [11:0] n_ctrl = m_ctrl;
        for (int n = 0; n < 3; n++) begin
            logic en_bit = (cur_ring == 2'd0) ? m_ctrl[4*n] : m_ctrl[4*n+1];
            logic hit    = reg_we && (reg_addr == 12'h309 + n);
            if (hit && reg_wdata[63:40] != 0) n_err = 1'b1;
            if (hit && reg_wdata[63:40] == 0) begin
                m_cnt[n] = reg_wdata[39:0];
            end else if (ev[n] && en_bit) begin
                if (m_cnt[n] == 40'hFF_FFFF_FFFF) n_ovf[n] = 1'b1;
                m_cnt[n] = m_cnt[n] + 40'd1;
            end
        end
        if (reg_we && reg_addr == 12'h38D) begin
            if (reg_wdata[63:12] == 0) n_ctrl = reg_wdata[11:0];
            else n_err = 1'b1;
        end
        m_ctrl = n_ctrl;
        m_ovf  = n_ovf;
        m_err  = n_err;
    endtask

    // inputs already set on the falling edge; compare, predict, advance
    task automatic cycle();
        #1;
        check(phase_tag, "rdata", reg_rdata, model_read(reg_addr));
        check("R9", "ctr_ovf", {61'h0, ctr_ovf}, {61'h0, m_ovf});
        check("R8", "reg_err", {63'h0, reg_err}, {63'h0, m_err});
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        reg_we = 1'b0; reg_addr = a;
        cycle();
    endtask

    task automatic run(input int cycles_n, input logic [2:0] e, input logic [1:0] r,
                       input logic [11:0] a);
        ev = e; cur_ring = r; reg_addr = a;
        for (int i = 0; i < cycles_n; i++) cycle();
        ev = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 3; n++) m_cnt[n] = '0;
        m_ctrl = '0; m_ovf = '0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values visible while reset is held
        #1;
        check("R1", "rdata in reset", reg_rdata, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        phase_tag = "R1";
        rd(12'h309); rd(12'h30A); rd(12'h30B); rd(12'h38D);

        // R3: each counter follows only its own event, all rings enabled
        wr(12'h38D, 64'h333);
        phase_tag = "R3";
        run(5, 3'b001, 2'd0, 12'h309);
        run(7, 3'b010, 2'd2, 12'h30A);
        run(9, 3'b100, 2'd3, 12'h30B);
        rd(12'h309); rd(12'h30A); rd(12'h30B);

        // R4: counter0 ring0 only, counter1 upper rings only, counter2 off
        wr(12'h38D, 64'h021);
        phase_tag = "R4";
        run(6, 3'b111, 2'd0, 12'h309);
        run(6, 3'b111, 2'd1, 12'h30A);
        run(4, 3'b111, 2'd3, 12'h30B);
        rd(12'h309); rd(12'h30A);

        // R5: upper field bits alone do nothing, yet read back
        phase_tag = "R5";
        wr(12'h38D, 64'hCCC);
        run(8, 3'b111, 2'd0, 12'h38D);
        run(8, 3'b111, 2'd2, 12'h309);
        wr(12'h38D, 64'hDEF);
        run(8, 3'b111, 2'd1, 12'h30B);
        rd(12'h38D);

        // R6: write collides with an increment
        phase_tag = "R6";
        wr(12'h38D, 64'h333);
        ev = 3'b111;
        wr(12'h30A, 64'h12_3456_789A);
        rd(12'h30A);
        wr(12'h309, 64'h0);
        ev = '0;
        rd(12'h309);

        // R7: reading while counting shows the pre-increment value
        phase_tag = "R7";
        run(5, 3'b001, 2'd1, 12'h309);

        // R8: reserved bits refused; increment still happens
        phase_tag = "R8";
        ev = 3'b010;
        wr(12'h30A, 64'h0000_0100_0000_0000);
        ev = '0;
        rd(12'h30A);
        wr(12'h38D, 64'h1000);
        rd(12'h38D);
        wr(12'h30B, 64'h8000_0000_0000_0005);
        rd(12'h30B);

        // R2: unmapped addresses
        phase_tag = "R2";
        wr(12'h308, 64'h55);
        wr(12'h30C, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h30C); rd(12'h38C); rd(12'h000);

        // R9: wrap at the top of the range
        phase_tag = "R9";
        wr(12'h30A, 64'hFF_FFFF_FFFE);
        run(4, 3'b010, 2'd0, 12'h30A);
        ev = 3'b111;
        wr(12'h30B, 64'hFF_FFFF_FFFF);
        wr(12'h30B, 64'hFF_FFFF_FFFF);   // load over a wrap: no overflow
        ev = '0;
        run(3, 3'b100, 2'd2, 12'h30B);

        // R10: control changes take effect one edge later
        phase_tag = "R10";
        ev = 3'b111; cur_ring = 2'd0;
        wr(12'h38D, 64'h000);
        wr(12'h38D, 64'h111);
        wr(12'h38D, 64'h222);
        ev = '0;
        rd(12'h309); rd(12'h30A); rd(12'h30B);

        // mixed pseudo-random traffic
        phase_tag = "R7";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom;
            ev = r[2:0];
            cur_ring = r[4:3];
            reg_we = (r[9:6] == 4'd0);
            case (r[12:10])
                3'd0: reg_addr = 12'h38D;
                3'd1: reg_addr = 12'h30C;
                3'd2: reg_addr = 12'h309;
                3'd3: reg_addr = 12'h30A;
                default: reg_addr = 12'h30B;
            endcase
            if (r[13]) reg_wdata = {$urandom, $urandom};
            else if (r[14]) reg_wdata = {24'h0, 16'hFFFF, 24'hFFFFF0 | 24'(r[18:15])};
            else reg_wdata = {52'h0, r[27:16]};
            cycle();
        end
        reg_we = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule